// File: doc/BRIEF.md
# Two-Way Set-Associative Address Translation Cache

This block keeps recently used page mappings so that a processor can turn a 64-bit virtual address into a 40-bit physical address without walking the page table. Pages are 16 KB. The low 14 bits of an address pass through unchanged. The 50 bits above them form the virtual page number: its low 7 bits select one of 128 sets and its upper 43 bits are compared as the tag. Each set holds two ways. A way stores a tag, a 26-bit physical page number, a valid bit, a recently-used bit, a modified (dirty) bit and two permission bits, one for reads and one for writes.

A lookup presents an address and an access kind. One cycle later the block returns exactly one of three outcomes. A hit returns the physical address and the entry's dirty state. A miss tells the surrounding logic to walk the page table. A fault means the mapping exists but does not allow this access. After a miss, the walker installs the mapping through the fill port. A single invalidate input empties the whole structure in one cycle.

The response register is a four-state machine. The states are RSP_IDLE (no lookup last cycle), RSP_HIT, RSP_MISS and RSP_FAULT. The transitions are taken on every clock edge from the current request:
- go_idle: no lookup is presented.
- go_miss: there is no valid tag match, or the lookup collides with a fill to the same set.
- go_fault: there is a match, but the permission bit for the access is clear.
- go_hit: there is a match and the access is allowed.

Fill victim choice is classified as PICK_MATCH, PICK_EMPTY, PICK_COLD or PICK_SWEEP.

Top module: `xlb_translation_buffer`

## Requirements
- R1: After reset all outputs are low and every entry is invalid, so any lookup misses.
- R2: A lookup presented in cycle t produces `rsp_valid` in cycle t+1 with exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` high. Without a lookup, `rsp_valid` is low in the next cycle.
- R3: The set index is `lk_vaddr[20:14]` and the tag is `lk_vaddr[63:21]`. A fill uses `fill_vpn[6:0]` as the set index and `fill_vpn[49:7]` as the tag. On a hit, `rsp_paddr` = {stored page number, `lk_vaddr[13:0]`}.
- R4: A lookup with no valid entry whose tag matches in the indexed set reports a miss, with `rsp_paddr` = 0, `rsp_dirty` = 0, and no change to any entry.
- R5: A read to an entry whose read permission is clear, or a write to an entry whose write permission is clear, reports a fault with `rsp_paddr` = 0. The entry's dirty and recently-used bits are left unchanged.
- R6: A permitted write hit sets the entry's dirty bit. `rsp_dirty` on a hit reports the dirty bit including the effect of the current access.
- R7: A permitted hit sets the entry's recently-used bit.
- R8: A fill picks its victim in this order: a way already holding the same tag; otherwise the lowest-numbered invalid way; otherwise the lowest-numbered way whose recently-used bit is clear; otherwise way 0, in which case the recently-used bits of all other ways in the set are cleared. The installed entry is valid with its recently-used bit set.
- R9: A fill stores the supplied page number, read and write permissions, and dirty flag. A later lookup of the same tag returns them. A refill of a present tag replaces it and creates no second copy.
- R10: When a fill and a lookup address the same set in the same cycle, the fill is installed and the lookup reports a miss with no side effect.
- R11: `inval_all` clears every valid bit in one cycle and takes priority over a fill in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write (1) or read (0) |
| lk_vaddr | input | 64 | Virtual address to translate |
| fill_valid | input | 1 | Install a mapping |
| fill_vpn | input | 50 | Virtual page number of the mapping |
| fill_ppn | input | 26 | Physical page number of the mapping |
| fill_can_rd | input | 1 | Read permission of the mapping |
| fill_can_wr | input | 1 | Write permission of the mapping |
| fill_dirty | input | 1 | Initial dirty flag of the mapping |
| inval_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response present (one cycle after a lookup) |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No translation held |
| rsp_fault | output | 1 | Translation held but access not permitted |
| rsp_dirty | output | 1 | Dirty state of the hit entry |
| rsp_paddr | output | 40 | Translated physical address on a hit, else 0 |

## Verification
The vector table drives several groups of lookups:
- Reads, writes and misses that differ only in tag or only in set index. These show that both address fields take part in the match.
- Read-only and write-only mappings accessed both ways. These separate a permission fault from a hit, and show that a refused write leaves the dirty bit clear.
- Four fills into one set. These separate the empty-way, cold-way and sweep choices of the victim picker.
- A second set where a hit between fills decides which way survives. This ties recently-used marking to replacement.
- A refill of an existing tag. This shows that the old copy is replaced and not duplicated.

Directed cases cover a fill and a lookup colliding on a set, an invalidate coinciding with a fill, and a reset in the middle of the run.

// File: rtl/xlb_pkg.sv
package xlb_pkg;

    // Permission bits held with every mapping
    typedef struct packed {
        logic can_rd;
        logic can_wr;
    } rights_t;

    // Registered lookup outcome
    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_HIT,
        RSP_MISS,
        RSP_FAULT
    } rsp_state_e;

    // Reason a victim way was chosen on fill
    typedef enum logic [1:0] {
        PICK_MATCH,
        PICK_EMPTY,
        PICK_COLD,
        PICK_SWEEP
    } pick_e;

endpackage

// File: rtl/xlb_way_bank.sv
module xlb_way_bank
    import xlb_pkg::*;
#(
    parameter int SET_W = 7,
    parameter int TAG_W = 43,
    parameter int PPN_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    // lookup read port
    input  logic [SET_W-1:0] look_set,
    output logic             look_valid,
    output logic [TAG_W-1:0] look_tag,
    output logic [PPN_W-1:0] look_ppn,
    output rights_t          look_rights,
    output logic             look_dirty,
    // fill read port
    input  logic [SET_W-1:0] fill_set,
    output logic             fill_valid,
    output logic             fill_ref,
    output logic [TAG_W-1:0] fill_tag,
    // updates
    input  logic             inst_en,
    input  logic [TAG_W-1:0] inst_tag,
    input  logic [PPN_W-1:0] inst_ppn,
    input  rights_t          inst_rights,
    input  logic             inst_dirty,
    input  logic             clr_ref,
    input  logic             touch_en,
    input  logic             touch_write
);

    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  ref_q;
    logic [SETS-1:0]  dirty_q;
    logic [TAG_W-1:0] tag_q    [SETS];
    logic [PPN_W-1:0] ppn_q    [SETS];
    rights_t          rights_q [SETS];

    // state bits with reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ref_q   <= '0;
        end else if (inv_all) begin
            valid_q <= '0;
            ref_q   <= '0;
        end else begin
            if (inst_en) begin
                valid_q[fill_set] <= 1'b1;
                ref_q[fill_set]   <= 1'b1;
            end else if (clr_ref) begin
                ref_q[fill_set]   <= 1'b0;
            end
            if (touch_en) begin
                ref_q[look_set] <= 1'b1;
            end
        end
    end

    // payload, only meaningful while valid
    always_ff @(posedge clk) begin
        if (inst_en && !inv_all) begin
            tag_q[fill_set]    <= inst_tag;
            ppn_q[fill_set]    <= inst_ppn;
            rights_q[fill_set] <= inst_rights;
            dirty_q[fill_set]  <= inst_dirty;
        end
        if (touch_en && touch_write) begin
            dirty_q[look_set] <= 1'b1;
        end
    end

    assign look_valid  = valid_q[look_set];
    assign look_tag    = tag_q[look_set];
    assign look_ppn    = ppn_q[look_set];
    assign look_rights = rights_q[look_set];
    assign look_dirty  = dirty_q[look_set];

    assign fill_valid  = valid_q[fill_set];
    assign fill_ref    = ref_q[fill_set];
    assign fill_tag    = tag_q[fill_set];

    // R11: an invalidate leaves no valid entry behind
    assert_inval_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_q == '0));

    // R8: an installed entry is valid and marked recently used
    assert_install_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_en && !inv_all) |=> (valid_q[$past(fill_set)] && ref_q[$past(fill_set)]));

endmodule

// File: rtl/xlb_victim.sv
module xlb_victim
    import xlb_pkg::*;
#(
    parameter int WAYS = 2
) (
    input  logic [WAYS-1:0] way_valid,
    input  logic [WAYS-1:0] way_ref,
    input  logic [WAYS-1:0] way_match,
    output logic [WAYS-1:0] pick_oh,
    output logic [WAYS-1:0] clr_mask,
    output pick_e           reason
);

    function automatic logic [WAYS-1:0] lowest_set(input logic [WAYS-1:0] v);
        logic [WAYS-1:0] r;
        r = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (v[i]) r = WAYS'(1) << i;
        end
        return r;
    endfunction

    always_comb begin
        if (|way_match)       reason = PICK_MATCH;
        else if (!(&way_valid)) reason = PICK_EMPTY;
        else if (!(&way_ref))   reason = PICK_COLD;
        else                  reason = PICK_SWEEP;
    end

    always_comb begin
        pick_oh  = '0;
        clr_mask = '0;
        unique case (reason)
            PICK_MATCH: pick_oh = lowest_set(way_match);
            PICK_EMPTY: pick_oh = lowest_set(~way_valid);
            PICK_COLD:  pick_oh = lowest_set(~way_ref);
            PICK_SWEEP: begin
                pick_oh  = WAYS'(1);
                clr_mask = ~WAYS'(1);
            end
            default:    pick_oh = WAYS'(1);
        endcase
    end

endmodule

// File: rtl/xlb_hit_check.sv
module xlb_hit_check
    import xlb_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int TAG_W = 43,
    parameter int PPN_W = 26
) (
    input  logic [TAG_W-1:0] key_tag,
    input  logic             is_write,
    input  logic [WAYS-1:0]  way_valid,
    input  logic [TAG_W-1:0] way_tag    [WAYS],
    input  logic [PPN_W-1:0] way_ppn    [WAYS],
    input  rights_t          way_rights [WAYS],
    input  logic [WAYS-1:0]  way_dirty,
    output logic             hit_any,
    output logic [WAYS-1:0]  hit_oh,
    output logic [PPN_W-1:0] sel_ppn,
    output logic             sel_dirty,
    output logic             perm_ok
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_oh[w] = way_valid[w] && (way_tag[w] == key_tag);
    end

    always_comb begin
        sel_ppn   = '0;
        sel_dirty = 1'b0;
        perm_ok   = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_oh[w]) begin
                sel_ppn   = sel_ppn | way_ppn[w];
                sel_dirty = sel_dirty | way_dirty[w];
                perm_ok   = perm_ok | (is_write ? way_rights[w].can_wr
                                                : way_rights[w].can_rd);
            end
        end
    end

    assign hit_any = |hit_oh;

endmodule

// File: rtl/xlb_translation_buffer.sv
module xlb_translation_buffer
    import xlb_pkg::*;
#(
    parameter int VA_W  = 64,
    parameter int PA_W  = 40,
    parameter int OFF_W = 14,
    parameter int SET_W = 7,
    parameter int WAYS  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic                     lk_write,
    input  logic [VA_W-1:0]          lk_vaddr,
    input  logic                     fill_valid,
    input  logic [VA_W-OFF_W-1:0]    fill_vpn,
    input  logic [PA_W-OFF_W-1:0]    fill_ppn,
    input  logic                     fill_can_rd,
    input  logic                     fill_can_wr,
    input  logic                     fill_dirty,
    input  logic                     inval_all,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic                     rsp_miss,
    output logic                     rsp_fault,
    output logic                     rsp_dirty,
    output logic [PA_W-1:0]          rsp_paddr
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int TAG_W = VPN_W - SET_W;
    localparam int PPN_W = PA_W - OFF_W;

    // address split
    logic [SET_W-1:0] look_set, fill_set;
    logic [TAG_W-1:0] look_tag, fill_tag;

    assign look_set = lk_vaddr[OFF_W +: SET_W];
    assign look_tag = lk_vaddr[VA_W-1 -: TAG_W];
    assign fill_set = fill_vpn[SET_W-1:0];
    assign fill_tag = fill_vpn[VPN_W-1 -: TAG_W];

    rights_t fill_rights;
    assign fill_rights = '{can_rd: fill_can_rd, can_wr: fill_can_wr};

    // per-way views
    logic [WAYS-1:0]  lv, ld, fv, fr, fm;
    logic [TAG_W-1:0] lt [WAYS];
    logic [TAG_W-1:0] ft [WAYS];
    logic [PPN_W-1:0] lp [WAYS];
    rights_t          lr [WAYS];

    logic [WAYS-1:0]  pick_oh, clr_mask, touch, hit_oh;
    pick_e            pick_why;
    logic             collide, fill_go, look_ok;
    logic             hit_any, perm_ok, sel_dirty;
    logic [PPN_W-1:0] sel_ppn;

    assign collide = lk_valid && fill_valid && (look_set == fill_set);
    assign fill_go = fill_valid && !inval_all;
    assign look_ok = lk_valid && !collide;
    assign touch   = (look_ok && hit_any && perm_ok) ? hit_oh : '0;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        xlb_way_bank #(
            .SET_W (SET_W),
            .TAG_W (TAG_W),
            .PPN_W (PPN_W)
        ) i_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .inv_all     (inval_all),
            .look_set    (look_set),
            .look_valid  (lv[w]),
            .look_tag    (lt[w]),
            .look_ppn    (lp[w]),
            .look_rights (lr[w]),
            .look_dirty  (ld[w]),
            .fill_set    (fill_set),
            .fill_valid  (fv[w]),
            .fill_ref    (fr[w]),
            .fill_tag    (ft[w]),
            .inst_en     (fill_go && pick_oh[w]),
            .inst_tag    (fill_tag),
            .inst_ppn    (fill_ppn),
            .inst_rights (fill_rights),
            .inst_dirty  (fill_dirty),
            .clr_ref     (fill_go && clr_mask[w]),
            .touch_en    (touch[w]),
            .touch_write (lk_write)
        );
        assign fm[w] = fv[w] && (ft[w] == fill_tag);
    end

    xlb_victim #(.WAYS(WAYS)) i_victim (
        .way_valid (fv),
        .way_ref   (fr),
        .way_match (fm),
        .pick_oh   (pick_oh),
        .clr_mask  (clr_mask),
        .reason    (pick_why)
    );

    xlb_hit_check #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .PPN_W (PPN_W)
    ) i_hit (
        .key_tag    (look_tag),
        .is_write   (lk_write),
        .way_valid  (lv),
        .way_tag    (lt),
        .way_ppn    (lp),
        .way_rights (lr),
        .way_dirty  (ld),
        .hit_any    (hit_any),
        .hit_oh     (hit_oh),
        .sel_ppn    (sel_ppn),
        .sel_dirty  (sel_dirty),
        .perm_ok    (perm_ok)
    );

    // response state machine
    rsp_state_e       rsp_q, rsp_d;
    logic [PA_W-1:0]  paddr_q;
    logic             dirty_q;

    always_comb begin
        rsp_d = RSP_IDLE;                       // go_idle
        if (lk_valid) begin
            if (!look_ok || !hit_any) rsp_d = RSP_MISS;   // go_miss
            else if (!perm_ok)        rsp_d = RSP_FAULT;  // go_fault
            else                      rsp_d = RSP_HIT;    // go_hit
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q   <= RSP_IDLE;
            paddr_q <= '0;
            dirty_q <= 1'b0;
        end else begin
            rsp_q   <= rsp_d;
            paddr_q <= (rsp_d == RSP_HIT) ? {sel_ppn, lk_vaddr[OFF_W-1:0]} : '0;
            dirty_q <= (rsp_d == RSP_HIT) && (sel_dirty || lk_write);
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        rsp_fault = 1'b0;
        unique case (rsp_q)
            RSP_IDLE:  ;
            RSP_HIT:   begin rsp_valid = 1'b1; rsp_hit   = 1'b1; end
            RSP_MISS:  begin rsp_valid = 1'b1; rsp_miss  = 1'b1; end
            RSP_FAULT: begin rsp_valid = 1'b1; rsp_fault = 1'b1; end
            default:   ;
        endcase
    end

    assign rsp_paddr = paddr_q;
    assign rsp_dirty = dirty_q;

    // R2: a lookup is answered next cycle with a single outcome
    assert_answer_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    assert_quiet_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

    // R3: the page offset passes through untranslated
    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    // R4, R5: no address or dirty state leaks on miss or fault
    assert_no_leak_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss || rsp_fault) |-> (rsp_paddr == '0 && !rsp_dirty));

    // R6: a permitted write reports a dirty entry
    assert_write_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && $past(lk_write)) |-> rsp_dirty);

    // R10: fill and lookup on the same set answer a miss
    assert_collide_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && fill_valid && (lk_vaddr[OFF_W +: SET_W] == fill_vpn[SET_W-1:0]))
        |=> rsp_miss);

    // R8: exactly one victim way per fill
    assert_one_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> ($countones(pick_oh) == 1));

endmodule

// File: tb/test_xlb_translation_buffer.sv
module test_xlb_translation_buffer;

    localparam logic [1:0] OP_LK = 2'd0;
    localparam logic [1:0] OP_FL = 2'd1;
    localparam logic [1:0] OP_IV = 2'd2;

    localparam logic [1:0] EX_HIT = 2'd0;
    localparam logic [1:0] EX_MIS = 2'd1;
    localparam logic [1:0] EX_FLT = 2'd2;
    localparam logic [1:0] EX_NA  = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic        wr;
        logic [42:0] tag;
        logic [6:0]  set;
        logic [13:0] off;
        logic [25:0] ppn;     // fill value, or expected value on a lookup
        logic        frd;
        logic        fwr;
        logic        fdirty;
        logic [1:0]  exp;
        logic        edirty;
    } vec_t;

    localparam int NV = 41;
    localparam logic [42:0] TMAX = 43'h7FF_FFFF_FFFF;

    localparam vec_t VEC [NV] = '{
        '{OP_LK,1'b0,43'h5,7'd3,14'h0000,26'h0,1'b0,1'b0,1'b0,EX_MIS,1'b0},       // 0 R1 empty
        '{OP_FL,1'b0,43'h5,7'd3,14'h0000,26'h123,1'b1,1'b1,1'b0,EX_NA,1'b0},      // 1 R9
        '{OP_LK,1'b0,43'h5,7'd3,14'h02AB,26'h123,1'b0,1'b0,1'b0,EX_HIT,1'b0},     // 2 R3
        '{OP_LK,1'b1,43'h5,7'd3,14'h0004,26'h123,1'b0,1'b0,1'b0,EX_HIT,1'b1},     // 3 R6
        '{OP_LK,1'b0,43'h5,7'd3,14'h0008,26'h123,1'b0,1'b0,1'b0,EX_HIT,1'b1},     // 4 R6
        '{OP_LK,1'b0,43'h6,7'd3,14'h0000,26'h0,1'b0,1'b0,1'b0,EX_MIS,1'b0},       // 5 R4 tag
        '{OP_LK,1'b0,43'h5,7'd4,14'h0000,26'h0,1'b0,1'b0,1'b0,EX_MIS,1'b0},       // 6 R3 set
        '{OP_FL,1'b0,43'h9,7'd10,14'h0000,26'h3FFFFFF,1'b1,1'b0,1'b0,EX_NA,1'b0}, // 7 R5 read-only
        '{OP_LK,1'b1,43'h9,7'd10,14'h0001,26'h0,1'b0,1'b0,1'b0,EX_FLT,1'b0},      // 8 R5
        '{OP_LK,1'b0,43'h9,7'd10,14'h3FFF,26'h3FFFFFF,1'b0,1'b0,1'b0,EX_HIT,1'b0},// 9 R5 dirty kept
        '{OP_FL,1'b0,43'h7,7'd11,14'h0000,26'h0ABCDE,1'b0,1'b1,1'b0,EX_NA,1'b0},  // 10 R5 write-only
        '{OP_LK,1'b0,43'h7,7'd11,14'h0000,26'h0,1'b0,1'b0,1'b0,EX_FLT,1'b0},      // 11 R5
        '{OP_LK,1'b1,43'h7,7'd11,14'h0010,26'h0ABCDE,1'b0,1'b0,1'b0,EX_HIT,1'b1}, // 12 R6
        '{OP_FL,1'b0,43'h100,7'd20,14'h0,26'h1,1'b1,1'b1,1'b0,EX_NA,1'b0},        // 13 R8 empty
        '{OP_FL,1'b0,43'h200,7'd20,14'h0,26'h2,1'b1,1'b1,1'b0,EX_NA,1'b0},        // 14 R8 empty
        '{OP_FL,1'b0,43'h300,7'd20,14'h0,26'h3,1'b1,1'b1,1'b0,EX_NA,1'b0},        // 15 R8 sweep
        '{OP_FL,1'b0,43'h400,7'd20,14'h0,26'h4,1'b1,1'b1,1'b0,EX_NA,1'b0},        // 16 R8 cold
        '{OP_LK,1'b0,43'h100,7'd20,14'h0,26'h0,1'b0,1'b0,1'b0,EX_MIS,1'b0},       // 17 R8
        '{OP_LK,1'b0,43'h200,7'd20,14'h0,26'h0,1'b0,1'b0,1'b0,EX_MIS,1'b0},       // 18 R8
        '{OP_LK,1'b0,43'h300,7'd20,14'h0,26'h3,1'b0,1'b0,1'b0,EX_HIT,1'b0},       // 19 R8
        '{OP_LK,1'b0,43'h400,7'd20,14'h0,26'h4,1'b0,1'b0,1'b0,EX_HIT,1'b0},       // 20 R8
        '{OP_FL,1'b0,43'h500,7'd30,14'h0,26'h11,1'b1,1'b1,1'b0,EX_NA,1'b0},       // 21 R7
        '{OP_FL,1'b0,43'h600,7'd30,14'h0,26'h12,1'b1,1'b1,1'b0,EX_NA,1'b0},       // 22 R7
        '{OP_FL,1'b0,43'h700,7'd30,14'h0,26'h13,1'b1,1'b1,1'b0,EX_NA,1'b0},       // 23 R7
        '{OP_LK,1'b0,43'h600,7'd30,14'h0,26'h12,1'b0,1'b0,1'b0,EX_HIT,1'b0},      // 24 R7 touch
        '{OP_FL,1'b0,43'h800,7'd30,14'h0,26'h14,1'b1,1'b1,1'b0,EX_NA,1'b0},       // 25 R7
        '{OP_LK,1'b0,43'h700,7'd30,14'h0,26'h0,1'b0,1'b0,1'b0,EX_MIS,1'b0},       // 26 R7
        '{OP_LK,1'b0,43'h600,7'd30,14'h0,26'h12,1'b0,1'b0,1'b0,EX_HIT,1'b0},      // 27 R7
        '{OP_LK,1'b0,43'h800,7'd30,14'h0,26'h14,1'b0,1'b0,1'b0,EX_HIT,1'b0},      // 28 R7
        '{OP_FL,1'b0,43'h5,7'd3,14'h0,26'h456,1'b1,1'b1,1'b0,EX_NA,1'b0},         // 29 R9 refill
        '{OP_LK,1'b0,43'h5,7'd3,14'h0,26'h456,1'b0,1'b0,1'b0,EX_HIT,1'b0},        // 30 R9
        '{OP_FL,1'b0,43'h8,7'd3,14'h0,26'h77,1'b1,1'b1,1'b0,EX_NA,1'b0},          // 31 R9
        '{OP_LK,1'b0,43'h5,7'd3,14'h0,26'h456,1'b0,1'b0,1'b0,EX_HIT,1'b0},        // 32 R9
        '{OP_LK,1'b0,43'h8,7'd3,14'h0,26'h77,1'b0,1'b0,1'b0,EX_HIT,1'b0},         // 33 R9
        '{OP_FL,1'b0,43'h1,7'd50,14'h0,26'h55,1'b1,1'b1,1'b1,EX_NA,1'b0},         // 34 R9 dirty fill
        '{OP_LK,1'b0,43'h1,7'd50,14'h0,26'h55,1'b0,1'b0,1'b0,EX_HIT,1'b1},        // 35 R9
        '{OP_FL,1'b0,TMAX,7'd127,14'h0,26'h2AAAAAA,1'b1,1'b1,1'b0,EX_NA,1'b0},    // 36 R3 edges
        '{OP_LK,1'b0,TMAX,7'd127,14'h3FFF,26'h2AAAAAA,1'b0,1'b0,1'b0,EX_HIT,1'b0},// 37 R3
        '{OP_IV,1'b0,43'h0,7'd0,14'h0,26'h0,1'b0,1'b0,1'b0,EX_NA,1'b0},           // 38 R11
        '{OP_LK,1'b0,43'h5,7'd3,14'h0,26'h0,1'b0,1'b0,1'b0,EX_MIS,1'b0},          // 39 R11
        '{OP_LK,1'b0,TMAX,7'd127,14'h0,26'h0,1'b0,1'b0,1'b0,EX_MIS,1'b0}          // 40 R11
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_write;
    logic [63:0] lk_vaddr;
    logic        fill_valid;
    logic [49:0] fill_vpn;
    logic [25:0] fill_ppn;
    logic        fill_can_rd, fill_can_wr, fill_dirty, inval_all;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
    logic [39:0] rsp_paddr;

    int n_vec = 0;
    int n_bad = 0;
    logic done = 1'b0;
    vec_t v;

    always #5 clk = ~clk;

    xlb_translation_buffer i_xlb_translation_buffer (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_can_rd(fill_can_rd), .fill_can_wr(fill_can_wr), .fill_dirty(fill_dirty),
        .inval_all(inval_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_dirty(rsp_dirty), .rsp_paddr(rsp_paddr)
    );

    // response bundle: {valid, hit, miss, fault, dirty, paddr}
    function automatic logic [44:0] mk_rsp(input logic [1:0] ex, input logic d,
                                           input logic [39:0] pa);
        case (ex)
            EX_HIT:  return {1'b1, 1'b1, 1'b0, 1'b0, d, pa};
            EX_MIS:  return {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 40'h0};
            EX_FLT:  return {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 40'h0};
            default: return 45'h0;
        endcase
    endfunction

    task automatic check_rsp(input string req, input logic [44:0] expv);
        logic [44:0] act;
        act = {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_paddr};
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 1'b0; lk_write = 1'b0; lk_vaddr = 64'h0;
        fill_valid = 1'b0; fill_vpn = 50'h0; fill_ppn = 26'h0;
        fill_can_rd = 1'b0; fill_can_wr = 1'b0; fill_dirty = 1'b0;
        inval_all = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic lookup(input logic w, input logic [42:0] t, input logic [6:0] s,
                          input logic [13:0] o);
        lk_valid = 1'b1; lk_write = w; lk_vaddr = {t, s, o};
    endtask

    task automatic fill(input logic [42:0] t, input logic [6:0] s, input logic [25:0] p);
        fill_valid = 1'b1; fill_vpn = {t, s}; fill_ppn = p;
        fill_can_rd = 1'b1; fill_can_wr = 1'b1; fill_dirty = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete (all R) actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check_rsp("R1 reset outputs", 45'h0);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            unique case (v.op)
                OP_LK: lookup(v.wr, v.tag, v.set, v.off);
                OP_FL: begin
                    fill(v.tag, v.set, v.ppn);
                    fill_can_rd = v.frd; fill_can_wr = v.fwr; fill_dirty = v.fdirty;
                end
                default: inval_all = 1'b1;
            endcase
            @(negedge clk);
            idle_inputs();
            if (v.op == OP_LK)
                check_rsp($sformatf("vector %0d lookup", i),
                          mk_rsp(v.exp, v.edirty, {v.ppn, v.off}));
            else
                check_rsp($sformatf("R2 vector %0d no lookup", i), 45'h0);
        end

        // R10: fill and lookup on one set in one cycle
        fill(43'h42, 7'd60, 26'h99);
        lookup(1'b0, 43'h42, 7'd60, 14'h5);
        @(negedge clk);
        idle_inputs();
        check_rsp("R10 collision miss", mk_rsp(EX_MIS, 1'b0, 40'h0));
        lookup(1'b0, 43'h42, 7'd60, 14'h5);
        @(negedge clk);
        idle_inputs();
        check_rsp("R10 fill installed", mk_rsp(EX_HIT, 1'b0, {26'h99, 14'h5}));

        // R11: invalidate wins over a same-cycle fill
        fill(43'h43, 7'd61, 26'h98);
        inval_all = 1'b1;
        @(negedge clk);
        idle_inputs();
        lookup(1'b0, 43'h43, 7'd61, 14'h0);
        @(negedge clk);
        idle_inputs();
        check_rsp("R11 fill dropped", mk_rsp(EX_MIS, 1'b0, 40'h0));
        lookup(1'b0, 43'h42, 7'd60, 14'h0);
        @(negedge clk);
        idle_inputs();
        check_rsp("R11 prior entry gone", mk_rsp(EX_MIS, 1'b0, 40'h0));

        // R2: idle cycle gives no response
        @(negedge clk);
        check_rsp("R2 idle", 45'h0);

        // R1: reset in mid-run empties the structure
        fill(43'h44, 7'd62, 26'h97);
        @(negedge clk);
        idle_inputs();
        do_reset();
        check_rsp("R1 outputs after reset", 45'h0);
        lookup(1'b0, 43'h44, 7'd62, 14'h0);
        @(negedge clk);
        idle_inputs();
        check_rsp("R1 entry cleared by reset", mk_rsp(EX_MIS, 1'b0, 40'h0));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule